// File: doc/BRIEF.md
# Guarded-Code Oscillator Control Registers

This block is an APB register slave that sets up a crystal oscillator. Software turns the oscillator on or off, picks its frequency band and pauses it. Each setting is accepted only when the written value matches one of a few fixed multi-bit codes, so a stray or corrupted write cannot change the oscillator by accident. The applied settings drive the oscillator model directly: an enable line, a 2-bit band select and a dormant line.

A rejected code on the enable or band field leaves that field unchanged. A rejected code on the pause word forces the oscillator awake. Every rejected code raises a sticky error flag in the status word, and software clears that flag by writing a one to it. The status word also shows the applied enable and band settings, together with the stable indication fed back from the startup logic.

Top module: `osc_ctl_regs`

## Requirements
- R1: After reset osc_en_o=0, osc_range_o=0 and osc_dormant_o=0. The control word reads 0x00D1EAA0, the pause word reads 0x77616B65 and the status error flag is 0.
- R2: Writing enable code 0xFAB to control bits 23:12 (offset 0x00) sets osc_en_o on the clock edge of the access phase. Writing 0xD1E clears it.
- R3: Writing band codes 0xAA0, 0xAA1, 0xAA2 or 0xAA3 to control bits 11:0 sets osc_range_o to 0, 1, 2 or 3.
- R4: An unlisted code in one control field leaves that field's applied value unchanged. A valid code in the other field of the same write still applies.
- R5: A control read returns {8'h00, applied enable code, applied band code}, so a rejected code never appears on readback.
- R6: A status read (offset 0x04) returns stable_i in bit 31, the error flag in bit 24, the applied enable in bit 12, the applied band in bits 1:0 and zero in all other bits.
- R7: An unlisted code written to the enable field, the band field or the pause word sets the error flag. The flag stays set until it is cleared.
- R8: Writing status with bit 24 set clears the error flag. A status write with bit 24 at 0 leaves the flag as it is. The other status bits ignore writes.
- R9: Writing 0x636F6D61 to the pause word (offset 0x08) sets osc_dormant_o. Writing 0x77616B65 clears it. A pause read returns the code of the applied state.
- R10: Any other value written to the pause word clears osc_dormant_o and sets the error flag.
- R11: pready_o is always 1 and pslverr_o is always 0. An unmapped or misaligned address reads as zero, and a write to it changes nothing.
- R12: A write takes effect only in the access phase (psel_i, penable_i and pwrite_i all high). A setup phase alone changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk_i | input | 1 | APB clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write strobe |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | Always ready |
| pslverr_o | output | 1 | Never signals an error |
| stable_i | input | 1 | Oscillator stable indication from the startup logic |
| osc_en_o | output | 1 | Oscillator enable |
| osc_range_o | output | 2 | Applied frequency band |
| osc_dormant_o | output | 1 | Oscillator pause request |

## Verification
The bench builds the block with ADDR_W=6, which gives a 64-byte address window. This puts both the top word 0x3C and the first unused word 0x0C within reach of the unmapped-address checks, and a misaligned offset is covered as well. The width is otherwise irrelevant to the guarded fields, which the bench drives with every valid code and with codes that differ from a valid one in a single nibble.

// File: rtl/osc_ctl_pkg.sv
package osc_ctl_pkg;
  localparam int DATA_W = 32;
  localparam int CODE_W = 12;

  localparam logic [CODE_W-1:0] EN_OFF_CODE = 12'hd1e;
  localparam logic [CODE_W-1:0] EN_ON_CODE  = 12'hfab;

  localparam logic [CODE_W-1:0] RNG_CODE0 = 12'haa0;
  localparam logic [CODE_W-1:0] RNG_CODE1 = 12'haa1;
  localparam logic [CODE_W-1:0] RNG_CODE2 = 12'haa2;
  localparam logic [CODE_W-1:0] RNG_CODE3 = 12'haa3;

  localparam logic [DATA_W-1:0] PAUSE_RUN   = 32'h77616b65;
  localparam logic [DATA_W-1:0] PAUSE_SLEEP = 32'h636f6d61;

  // word indices (byte offset >> 2)
  localparam int WIDX_CTRL  = 0;
  localparam int WIDX_STAT  = 1;
  localparam int WIDX_PAUSE = 2;

  localparam int BAD_BIT = 24;

  typedef struct packed {
    logic ctrl;
    logic stat;
    logic pause;
  } reg_sel_t;
endpackage

// File: rtl/osc_ctl_field.sv
module osc_ctl_field #(
  parameter int W = 12,
  parameter int N = 2,
  parameter logic [N*W-1:0] CODES = '0,
  parameter int RST_IDX = 0,
  parameter bit BAD_FORCE = 1'b0,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [W-1:0]  wdata_i,
  output logic [IW-1:0] sel_o,
  output logic [W-1:0]  code_o,
  output logic          bad_o
);
  logic [N-1:0]  hit;
  logic [IW-1:0] hit_idx;
  logic          match;
  logic [IW-1:0] sel_q;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = (wdata_i == CODES[i*W +: W]);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++)
      if (hit[i]) hit_idx = IW'(i);
  end

  assign match = |hit;
  assign bad_o = we_i & ~match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            sel_q <= IW'(RST_IDX);
    else if (we_i) begin
      if (match)            sel_q <= hit_idx;
      else if (BAD_FORCE)   sel_q <= IW'(RST_IDX);
    end
  end

  always_comb begin
    code_o = '0;
    for (int i = 0; i < N; i++)
      if (sel_q == IW'(i)) code_o = CODES[i*W +: W];
  end

  assign sel_o = sel_q;

  if (BAD_FORCE) begin : g_force
    a_r10_reject_forces_default: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && !match) |=> (sel_q == IW'(RST_IDX)));
  end else begin : g_hold
    a_r4_reject_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && !match) |=> $stable(sel_q));
  end
endmodule

// File: rtl/osc_ctl_decode.sv
module osc_ctl_decode
  import osc_ctl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  output reg_sel_t          hit_o,
  output logic              wr_o,
  output logic              rd_o
);
  localparam int WW = ADDR_W - 2;

  logic          aligned;
  logic [WW-1:0] widx;

  assign aligned = (paddr_i[1:0] == 2'b00);
  assign widx    = paddr_i[ADDR_W-1:2];

  assign hit_o.ctrl  = aligned && (widx == WW'(WIDX_CTRL));
  assign hit_o.stat  = aligned && (widx == WW'(WIDX_STAT));
  assign hit_o.pause = aligned && (widx == WW'(WIDX_PAUSE));

  assign wr_o = psel_i & penable_i & pwrite_i;
  assign rd_o = psel_i & ~pwrite_i;
endmodule

// File: rtl/osc_ctl_status.sv
module osc_ctl_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic bad_o
);
  logic bad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bad_q <= 1'b0;
    else if (set_i) bad_q <= 1'b1;
    else if (clr_i) bad_q <= 1'b0;
  end

  assign bad_o = bad_q;

  a_r7_bad_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> bad_q);
  a_r8_clear_drops_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !bad_q);
  a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_q && !clr_i) |=> bad_q);
endmodule

// File: rtl/osc_ctl_regs.sv
module osc_ctl_regs
  import osc_ctl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              pclk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [31:0]       pwdata_i,
  output logic [31:0]       prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  input  logic              stable_i,
  output logic              osc_en_o,
  output logic [1:0]        osc_range_o,
  output logic              osc_dormant_o
);
  reg_sel_t hit;
  logic     wr, rd;
  logic     wr_ctrl, wr_stat, wr_pause;

  logic              en_sel, pause_sel;
  logic [1:0]        rng_sel;
  logic [CODE_W-1:0] en_code, rng_code;
  logic [DATA_W-1:0] pause_code;
  logic              en_bad, rng_bad, pause_bad;
  logic              bad_flag;
  logic [31:0]       stat_word;

  osc_ctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .psel_i   (psel_i),
    .penable_i(penable_i),
    .pwrite_i (pwrite_i),
    .paddr_i  (paddr_i),
    .hit_o    (hit),
    .wr_o     (wr),
    .rd_o     (rd)
  );

  assign wr_ctrl  = wr & hit.ctrl;
  assign wr_stat  = wr & hit.stat;
  assign wr_pause = wr & hit.pause;

  osc_ctl_field #(
    .W(CODE_W), .N(2), .CODES({EN_ON_CODE, EN_OFF_CODE}),
    .RST_IDX(0), .BAD_FORCE(1'b0)
  ) u_en (
    .clk_i(pclk_i), .rst_ni(rst_ni), .we_i(wr_ctrl),
    .wdata_i(pwdata_i[23:12]), .sel_o(en_sel), .code_o(en_code), .bad_o(en_bad)
  );

  osc_ctl_field #(
    .W(CODE_W), .N(4), .CODES({RNG_CODE3, RNG_CODE2, RNG_CODE1, RNG_CODE0}),
    .RST_IDX(0), .BAD_FORCE(1'b0)
  ) u_rng (
    .clk_i(pclk_i), .rst_ni(rst_ni), .we_i(wr_ctrl),
    .wdata_i(pwdata_i[11:0]), .sel_o(rng_sel), .code_o(rng_code), .bad_o(rng_bad)
  );

  osc_ctl_field #(
    .W(DATA_W), .N(2), .CODES({PAUSE_SLEEP, PAUSE_RUN}),
    .RST_IDX(0), .BAD_FORCE(1'b1)
  ) u_pause (
    .clk_i(pclk_i), .rst_ni(rst_ni), .we_i(wr_pause),
    .wdata_i(pwdata_i), .sel_o(pause_sel), .code_o(pause_code), .bad_o(pause_bad)
  );

  osc_ctl_status u_stat (
    .clk_i (pclk_i),
    .rst_ni(rst_ni),
    .set_i (en_bad | rng_bad | pause_bad),
    .clr_i (wr_stat & pwdata_i[BAD_BIT]),
    .bad_o (bad_flag)
  );

  assign stat_word = {stable_i, 6'b0, bad_flag, 11'b0, en_sel, 10'b0, rng_sel};

  always_comb begin
    prdata_o = '0;
    if (rd) begin
      if (hit.ctrl)       prdata_o = {8'h00, en_code, rng_code};
      else if (hit.stat)  prdata_o = stat_word;
      else if (hit.pause) prdata_o = pause_code;
    end
  end

  assign pready_o      = 1'b1;
  assign pslverr_o     = 1'b0;
  assign osc_en_o      = en_sel;
  assign osc_range_o   = rng_sel;
  assign osc_dormant_o = pause_sel;

  a_r2_enable_applies: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    (wr_ctrl && pwdata_i[23:12] == EN_ON_CODE) |=> osc_en_o);
  a_r2_disable_applies: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    (wr_ctrl && pwdata_i[23:12] == EN_OFF_CODE) |=> !osc_en_o);
  a_r9_sleep_applies: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    (wr_pause && pwdata_i == PAUSE_SLEEP) |=> osc_dormant_o);
  a_r12_no_access_no_change: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    !(psel_i && penable_i && pwrite_i) |=>
      ($stable(osc_en_o) && $stable(osc_range_o) && $stable(osc_dormant_o)));
endmodule

// File: tb/osc_ctl_regs_test.sv
module osc_ctl_regs_test;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [31:0]   pwdata = '0;
  logic [31:0]   prdata;
  logic          pready, pslverr;
  logic          stable = 1'b0;
  logic          en, dormant;
  logic [1:0]    rng;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  osc_ctl_regs #(.ADDR_W(AW)) uut (
    .pclk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .pslverr_o(pslverr), .stable_i(stable),
    .osc_en_o(en), .osc_range_o(rng), .osc_dormant_o(dormant)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apb_write(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    #1;
  endtask

  task automatic apb_read(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1;
    d = prdata;
    check("R11 pready", {31'b0, pready}, 32'h1);
    check("R11 pslverr", {31'b0, pslverr}, 32'h0);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 en", {31'b0, en}, 32'h0);
    check("R1 range", {30'b0, rng}, 32'h0);
    check("R1 dormant", {31'b0, dormant}, 32'h0);
    apb_read(6'h00, d); check("R1 ctrl read", d, 32'h00d1eaa0);
    apb_read(6'h08, d); check("R1 pause read", d, 32'h77616b65);
    apb_read(6'h04, d); check("R1 status read", d, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    apb_write(6'h00, 32'h00fabaa2);
    check("R2 enable on", {31'b0, en}, 32'h1);
    check("R3 range 2", {30'b0, rng}, 32'h2);
    stable = 1'b1;
    apb_read(6'h04, d); check("R6 status word", d, 32'h80001002);
    apb_write(6'h00, 32'h00d1eaa1);
    check("R2 enable off", {31'b0, en}, 32'h0);
    apb_read(6'h04, d); check("R6 status off", d, 32'h80000001);
    stable = 1'b0;
  endtask

  task automatic t_ranges();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin
      apb_write(6'h00, 32'h00fab000 | (32'haa0 + i));
      check("R3 range", {30'b0, rng}, i);
      apb_read(6'h00, d); check("R5 ctrl readback", d, 32'h00fab000 | (32'haa0 + i));
    end
    apb_read(6'h04, d); check("R7 no flag on valid", d, 32'h00001003);
  endtask

  task automatic t_reject();
    logic [31:0] d;
    apb_write(6'h00, 32'h00fabaa1);
    apb_write(6'h00, 32'h00fbbaa2);
    check("R4 bad enable kept", {31'b0, en}, 32'h1);
    check("R4 range applies", {30'b0, rng}, 32'h2);
    apb_read(6'h04, d); check("R7 flag set", d, 32'h01001002);
    apb_write(6'h00, 32'h00d1eab2);
    check("R4 enable applies", {31'b0, en}, 32'h0);
    check("R4 bad range kept", {30'b0, rng}, 32'h2);
    apb_read(6'h00, d); check("R5 rejected not visible", d, 32'h00d1eaa2);
    apb_read(6'h04, d); check("R7 flag sticky", d, 32'h01000002);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    apb_write(6'h04, 32'hfeffffff);
    apb_read(6'h04, d); check("R8 bit24 zero keeps", d, 32'h01000002);
    check("R8 outputs untouched", {29'b0, en, rng}, 32'h2);
    apb_write(6'h04, 32'h01000000);
    apb_read(6'h04, d); check("R8 cleared", d, 32'h00000002);
  endtask

  task automatic t_pause();
    logic [31:0] d;
    apb_write(6'h08, 32'h636f6d61);
    check("R9 dormant", {31'b0, dormant}, 32'h1);
    apb_read(6'h08, d); check("R9 pause read sleep", d, 32'h636f6d61);
    apb_write(6'h08, 32'h77616b65);
    check("R9 wake", {31'b0, dormant}, 32'h0);
    apb_read(6'h04, d); check("R9 no flag", d, 32'h00000002);
    apb_write(6'h08, 32'h636f6d61);
    apb_write(6'h08, 32'h636f6d60);
    check("R10 bad forces wake", {31'b0, dormant}, 32'h0);
    apb_read(6'h08, d); check("R10 pause read", d, 32'h77616b65);
    apb_read(6'h04, d); check("R10 flag set", d, 32'h01000002);
    apb_write(6'h04, 32'h01000000);
  endtask

  task automatic t_bus();
    logic [31:0] d;
    apb_read(6'h0c, d); check("R11 unmapped 0x0c", d, 32'h0);
    apb_read(6'h3c, d); check("R11 unmapped 0x3c", d, 32'h0);
    apb_read(6'h01, d); check("R11 misaligned", d, 32'h0);
    apb_write(6'h0c, 32'h00fabaa0);
    apb_write(6'h01, 32'h00fabaa0);
    apb_write(6'h3c, 32'h636f6d61);
    check("R11 unmapped write", {28'b0, en, dormant, rng}, 32'h2);
    apb_read(6'h04, d); check("R11 no flag", d, 32'h00000002);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 6'h00; pwdata = 32'h00fabaa3;
    @(negedge clk);
    psel = 1'b0; pwrite = 1'b0;
    #1;
    check("R12 setup only", {29'b0, en, rng}, 32'h2);
    @(negedge clk);
    psel = 1'b0; penable = 1'b1; pwrite = 1'b1; paddr = 6'h08; pwdata = 32'h636f6d61;
    @(negedge clk);
    penable = 1'b0; pwrite = 1'b0;
    #1;
    check("R12 enable without select", {31'b0, dormant}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual %h expected %h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_enable();
    t_ranges();
    t_reject();
    t_clear();
    t_pause();
    t_bus();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule